// File: doc/BRIEF.md
# No-Load Deep Sleep Mode Controller

This block decides when a primary-side regulated flyback controller drops into a low-power burst mode at no load, and when it returns to normal regulation. Once per switching cycle a strobe delivers the sampled output-voltage error code as an integer in millivolts. The strobe also carries two flags: one says the cycle ran at the minimum switching frequency, the other says the gate on-time reached its maximum. The block turns these into a deep-mode flag, an oscillator period select and the regulation reference code that the voltage loop should use.

To enter the mode, a run of qualifying cycles must exceed a programmable length, and every one of those cycles must show the sample above the upper band edge while the converter runs at minimum frequency. There are two ways out. A slow exit happens when the sample falls under the lower band edge while on-time is already at its maximum. A fast exit is taken for a load step, when the sample drops under a lower dynamic threshold. While in deep mode the oscillator is held at its 800 µs period (1.25 kHz). A hysteretic band between 2525 mV and 2550 mV then decides whether the next cycles deliver pulses.

Top module: `nlsleep_ctrl`

## Requirements
- R1: When `rst` or `prot_shutdown` is high at a clock edge, the block leaves that edge in normal mode. After that edge `deep_mode`=0 and `pulse_req`=1, and the qualifying-cycle count is zero.
- R2: State changes only at edges where `smp_stb`=1. With the strobe low, no value on `err_mv`, `at_min_freq` or `at_max_ton` changes any output.
- R3: In normal mode, a strobe with `at_min_freq`=1 and `err_mv` strictly above 2550 counts as qualifying. Any other strobe clears the count. A sample equal to 2550 does not qualify.
- R4: Entry happens on the qualifying strobe that arrives when ENTRY_CYC qualifying strobes have already been counted. That is ENTRY_CYC+1 consecutive qualifying strobes. `deep_mode` reads 1 after that edge.
- R5: In deep mode, a strobe with `err_mv` below 2525 and `at_max_ton`=1 returns the block to normal mode. With `at_max_ton`=0, or with a sample of exactly 2525, the block stays in deep mode.
- R6: In deep mode, a strobe with `err_mv` below 2400 returns the block to normal mode whatever `at_max_ton` is. A sample of exactly 2400 does not trigger this exit.
- R7: `period_sel` is 1 (800 µs period, 1.25 kHz) exactly while in deep mode, and 0 otherwise.
- R8: `ref_mv` is 2550 in deep mode and 2500 in normal mode, and it is back to 2500 from the edge of exit onward.
- R9: `pulse_req` is 1 in normal mode and becomes 0 on entry. In deep mode, a strobe whose sample is above 2550 clears it. A strobe whose sample is below 2525 without causing an exit sets it. A sample from 2525 to 2550 inclusive leaves it unchanged.
- R10: Exit clears the qualifying count. A new entry needs a full fresh run of ENTRY_CYC+1 qualifying strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prot_shutdown | input | 1 | Protection shutdown, forces normal mode synchronously |
| smp_stb | input | 1 | One-cycle strobe per switching cycle |
| err_mv | input | CODE_W | Sampled voltage error code in mV |
| at_min_freq | input | 1 | Cycle ran at minimum switching frequency |
| at_max_ton | input | 1 | Cycle reached maximum on-time |
| deep_mode | output | 1 | 1 while in deep sleep mode |
| period_sel | output | 1 | 1 selects the 800 µs oscillator period |
| ref_mv | output | CODE_W | Active regulation reference in mV |
| pulse_req | output | 1 | Hysteretic band result: 1 lets cycles deliver pulses |

## Verification
The assertions assume that `smp_stb` is a single-cycle pulse and that `err_mv` and both flags are meaningful only when it is high. They also assume that reset or shutdown may arrive in any cycle, including one that carries a strobe. The stimulus sweeps the sample through every threshold edge, in 5 mV steps and at the exact boundary codes. It tries all combinations of the two flags, with the strobe both high and low. Every input change is made at the falling edge, so it always lies in that legal space.

// File: rtl/nlsleep_pkg.sv
package nlsleep_pkg;
  localparam int CODE_W = 12;
  typedef logic [CODE_W-1:0] mv_t;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_DEEP   = 1'b1
  } mode_e;

  // strict greater-than threshold test
  function automatic logic mv_above(input mv_t v, input mv_t thr);
    return v > thr;
  endfunction

  // strict less-than threshold test
  function automatic logic mv_below(input mv_t v, input mv_t thr);
    return v < thr;
  endfunction

  // hysteretic band: high edge stops pulses, low edge restarts them
  function automatic logic band_next(input logic cur, input logic over_hi,
                                     input logic under_lo);
    if (over_hi)       return 1'b0;
    else if (under_lo) return 1'b1;
    else               return cur;
  endfunction
endpackage

// File: rtl/nlsleep_run_cnt.sv
module nlsleep_run_cnt #(
  parameter int ENTRY_CYC = 8
) (
  input  logic clk,
  input  logic clr,
  input  logic stb,
  input  logic qualify,
  input  logic hold_zero,
  output logic run_full
);
  localparam int CNT_W = (ENTRY_CYC < 1) ? 1 : $clog2(ENTRY_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ENTRY_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr || hold_zero) begin
      cnt_q <= '0;
    end else if (stb) begin
      if (!qualify)            cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_full = (cnt_q == LIMIT);
endmodule

// File: rtl/nlsleep_mode_fsm.sv
module nlsleep_mode_fsm
  import nlsleep_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic stb,
  input  logic qualify,
  input  logic run_full,
  input  logic under_lo,
  input  logic under_dyn,
  input  logic max_ton,
  output logic deep,
  output logic enter_evt,
  output logic exit_slow_evt,
  output logic exit_dyn_evt
);
  mode_e mode_q;

  assign enter_evt     = stb && (mode_q == MODE_NORMAL) && qualify && run_full;
  assign exit_slow_evt = stb && (mode_q == MODE_DEEP) && under_lo && max_ton;
  assign exit_dyn_evt  = stb && (mode_q == MODE_DEEP) && under_dyn;

  always_ff @(posedge clk) begin
    if (clr) begin
      mode_q <= MODE_NORMAL;
    end else begin
      unique case (mode_q)
        MODE_NORMAL: if (enter_evt) mode_q <= MODE_DEEP;
        MODE_DEEP:   if (exit_slow_evt || exit_dyn_evt) mode_q <= MODE_NORMAL;
        default:     mode_q <= MODE_NORMAL;
      endcase
    end
  end

  assign deep = (mode_q == MODE_DEEP);
endmodule

// File: rtl/nlsleep_band.sv
module nlsleep_band
  import nlsleep_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic stb,
  input  logic deep,
  input  logic enter_evt,
  input  logic exit_evt,
  input  logic over_hi,
  input  logic under_lo,
  output logic pulse_req
);
  logic band_q;

  always_ff @(posedge clk) begin
    if (clr || exit_evt)    band_q <= 1'b1;
    else if (enter_evt)     band_q <= 1'b0;
    else if (stb && deep)   band_q <= band_next(band_q, over_hi, under_lo);
  end

  assign pulse_req = band_q;
endmodule

// File: rtl/nlsleep_ctrl.sv
module nlsleep_ctrl
  import nlsleep_pkg::*;
#(
  parameter int  ENTRY_CYC   = 8,
  parameter mv_t BAND_HI_MV  = 12'd2550,
  parameter mv_t BAND_LO_MV  = 12'd2525,
  parameter mv_t DYN_MV      = 12'd2400,
  parameter mv_t NORM_REF_MV = 12'd2500,
  parameter mv_t DEEP_REF_MV = 12'd2550
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_shutdown,
  input  logic              smp_stb,
  input  logic [CODE_W-1:0] err_mv,
  input  logic              at_min_freq,
  input  logic              at_max_ton,
  output logic              deep_mode,
  output logic              period_sel,
  output logic [CODE_W-1:0] ref_mv,
  output logic              pulse_req
);
  logic clr_all;
  logic over_hi, under_lo, under_dyn, qualify;
  logic run_full;
  logic enter_evt, exit_slow_evt, exit_dyn_evt, exit_evt;

  assign clr_all   = rst || prot_shutdown;
  assign over_hi   = mv_above(err_mv, BAND_HI_MV);
  assign under_lo  = mv_below(err_mv, BAND_LO_MV);
  assign under_dyn = mv_below(err_mv, DYN_MV);
  assign qualify   = at_min_freq && over_hi;

  nlsleep_run_cnt #(.ENTRY_CYC(ENTRY_CYC)) u_run (
    .clk       (clk),
    .clr       (clr_all),
    .stb       (smp_stb),
    .qualify   (qualify),
    .hold_zero (deep_mode),
    .run_full  (run_full)
  );

  nlsleep_mode_fsm u_fsm (
    .clk           (clk),
    .clr           (clr_all),
    .stb           (smp_stb),
    .qualify       (qualify),
    .run_full      (run_full),
    .under_lo      (under_lo),
    .under_dyn     (under_dyn),
    .max_ton       (at_max_ton),
    .deep          (deep_mode),
    .enter_evt     (enter_evt),
    .exit_slow_evt (exit_slow_evt),
    .exit_dyn_evt  (exit_dyn_evt)
  );

  assign exit_evt = exit_slow_evt || exit_dyn_evt;

  nlsleep_band u_band (
    .clk       (clk),
    .clr       (clr_all),
    .stb       (smp_stb),
    .deep      (deep_mode),
    .enter_evt (enter_evt),
    .exit_evt  (exit_evt),
    .over_hi   (over_hi),
    .under_lo  (under_lo),
    .pulse_req (pulse_req)
  );

  assign period_sel = deep_mode;
  assign ref_mv     = deep_mode ? DEEP_REF_MV : NORM_REF_MV;
endmodule

// File: rtl/nlsleep_ctrl_chk.sv
module nlsleep_ctrl_chk
  import nlsleep_pkg::*;
#(
  parameter int  ENTRY_CYC   = 8,
  parameter mv_t BAND_HI_MV  = 12'd2550,
  parameter mv_t BAND_LO_MV  = 12'd2525,
  parameter mv_t DYN_MV      = 12'd2400,
  parameter mv_t NORM_REF_MV = 12'd2500,
  parameter mv_t DEEP_REF_MV = 12'd2550
) (
  input logic              clk,
  input logic              rst,
  input logic              prot_shutdown,
  input logic              smp_stb,
  input logic [CODE_W-1:0] err_mv,
  input logic              at_min_freq,
  input logic              at_max_ton,
  input logic              deep_mode,
  input logic              period_sel,
  input logic [CODE_W-1:0] ref_mv,
  input logic              pulse_req,
  input logic              enter_evt,
  input logic              exit_slow_evt,
  input logic              exit_dyn_evt
);
  logic clr_q;
  int   qual_run;

  always_ff @(posedge clk) begin
    clr_q <= rst || prot_shutdown;
    if (rst || prot_shutdown || deep_mode) qual_run <= 0;
    else if (smp_stb) qual_run <= (at_min_freq && err_mv > BAND_HI_MV) ? qual_run + 1 : 0;
  end

  // R1
  always @(posedge clk) if (clr_q === 1'b1)
    clear_state_chk: assert (!deep_mode && pulse_req);

  // R4
  always @(posedge clk) if (enter_evt === 1'b1 && !rst && !prot_shutdown)
    entry_run_chk: assert (qual_run >= ENTRY_CYC);

  // R2
  strobe_only_chk: assert property (@(posedge clk) disable iff (rst || prot_shutdown)
    !smp_stb |=> $stable(deep_mode) && $stable(pulse_req));

  // R4
  entry_cause_chk: assert property (@(posedge clk) disable iff (rst || prot_shutdown)
    $rose(deep_mode) |-> $past(smp_stb && at_min_freq && (err_mv > BAND_HI_MV)));

  // R5
  exit_cause_chk: assert property (@(posedge clk) disable iff (rst || prot_shutdown)
    ($fell(deep_mode) && !$past(rst || prot_shutdown)) |->
      $past(smp_stb && ((err_mv < DYN_MV) || ((err_mv < BAND_LO_MV) && at_max_ton))));

  // R6
  dyn_exit_chk: assert property (@(posedge clk) disable iff (rst || prot_shutdown)
    (deep_mode && smp_stb && (err_mv < DYN_MV)) |=> !deep_mode);

  // R7
  deep_out_chk: assert property (@(posedge clk) disable iff (rst || prot_shutdown)
    deep_mode |-> period_sel && (ref_mv == DEEP_REF_MV));

  // R8
  norm_out_chk: assert property (@(posedge clk) disable iff (rst || prot_shutdown)
    !deep_mode |-> !period_sel && (ref_mv == NORM_REF_MV) && pulse_req);

  // R9
  band_stop_chk: assert property (@(posedge clk) disable iff (rst || prot_shutdown)
    (deep_mode && smp_stb && (err_mv > BAND_HI_MV)) |=> !pulse_req);

  // R10
  exit_evt_chk: assert property (@(posedge clk) disable iff (rst || prot_shutdown)
    (exit_slow_evt || exit_dyn_evt) |=> !deep_mode);
endmodule

bind nlsleep_ctrl nlsleep_ctrl_chk #(
  .ENTRY_CYC   (ENTRY_CYC),
  .BAND_HI_MV  (BAND_HI_MV),
  .BAND_LO_MV  (BAND_LO_MV),
  .DYN_MV      (DYN_MV),
  .NORM_REF_MV (NORM_REF_MV),
  .DEEP_REF_MV (DEEP_REF_MV)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .prot_shutdown (prot_shutdown),
  .smp_stb       (smp_stb),
  .err_mv        (err_mv),
  .at_min_freq   (at_min_freq),
  .at_max_ton    (at_max_ton),
  .deep_mode     (deep_mode),
  .period_sel    (period_sel),
  .ref_mv        (ref_mv),
  .pulse_req     (pulse_req),
  .enter_evt     (enter_evt),
  .exit_slow_evt (exit_slow_evt),
  .exit_dyn_evt  (exit_dyn_evt)
);

// File: tb/nlsleep_ctrl_bench.sv
module nlsleep_ctrl_bench;
  localparam int RUN_N = 4;
  localparam int HI = 2550, LO = 2525, DYN = 2400, NREF = 2500, DREF = 2550;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prot_shutdown = 1'b0;
  logic        smp_stb = 1'b0;
  logic [11:0] err_mv = 12'd2500;
  logic        at_min_freq = 1'b0;
  logic        at_max_ton = 1'b0;
  logic        deep_mode, period_sel, pulse_req;
  logic [11:0] ref_mv;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // bench-side model state
  int m_deep = 0, m_cnt = 0, m_band = 1;

  always #5 clk = ~clk;

  nlsleep_ctrl #(.ENTRY_CYC(RUN_N)) u_nlsleep_ctrl (
    .clk(clk), .rst(rst), .prot_shutdown(prot_shutdown), .smp_stb(smp_stb),
    .err_mv(err_mv), .at_min_freq(at_min_freq), .at_max_ton(at_max_ton),
    .deep_mode(deep_mode), .period_sel(period_sel), .ref_mv(ref_mv),
    .pulse_req(pulse_req)
  );

  task automatic model_edge(input int r, input int s, input int e, input int mf, input int mt);
    if (r != 0) begin
      m_deep = 0; m_cnt = 0; m_band = 1;
    end else if (s != 0) begin
      if (m_deep != 0) begin
        if (e < DYN || (e < LO && mt != 0)) begin
          m_deep = 0; m_cnt = 0; m_band = 1;
        end else if (e > HI) m_band = 0;
        else if (e < LO) m_band = 1;
      end else if (mf != 0 && e > HI) begin
        if (m_cnt >= RUN_N) begin m_deep = 1; m_cnt = 0; m_band = 0; end
        else m_cnt = m_cnt + 1;
      end else m_cnt = 0;
    end
  endtask

  task automatic cmp(input string tag, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // drive at negedge, clock once, compare at the following negedge
  task automatic apply(input string tag, input int s, input int e, input int mf,
                       input int mt, input int pr);
    smp_stb = (s != 0); err_mv = 12'(e); at_min_freq = (mf != 0);
    at_max_ton = (mt != 0); prot_shutdown = (pr != 0);
    @(posedge clk);
    model_edge(int'(rst) | pr, s, e, mf, mt);
    @(negedge clk);
    cmp(tag, "deep_mode", int'(deep_mode), m_deep);
    cmp("R7", "period_sel", int'(period_sel), m_deep);
    cmp("R8", "ref_mv", int'(ref_mv), (m_deep != 0) ? DREF : NREF);
    cmp("R9", "pulse_req", int'(pulse_req), m_band);
  endtask

  task automatic enter_deep(input string tag);
    for (int i = 0; i <= RUN_N; i++) apply(tag, 1, 2600, 1, 0, 0);
  endtask

  initial begin
    rst = 1'b1;
    @(negedge clk);
    apply("R1", 0, 2500, 0, 0, 0);
    rst = 1'b0;
    // R2: qualifying inputs without strobe never count
    for (int i = 0; i < 12; i++) apply("R2", 0, 2700, 1, 0, 0);
    // R3: equal-to-threshold breaks the run, so 4 more do not enter, 5th does (R4)
    for (int i = 0; i < 3; i++) apply("R3", 1, 2600, 1, 0, 0);
    apply("R3", 1, 2550, 1, 0, 0);
    for (int i = 0; i < RUN_N; i++) apply("R3", 1, 2551, 1, 0, 0);
    apply("R4", 1, 2551, 1, 0, 0);
    // R2: in deep mode a non-strobed exit-level sample is ignored
    apply("R2", 0, 2000, 0, 1, 0);
    // R9: band sweep downward then upward, no max on-time
    for (int e = 2600; e >= 2400; e -= 5) apply("R9", 1, e, 0, 0, 0);
    for (int e = 2400; e <= 2600; e += 5) apply("R9", 1, e, 0, 0, 0);
    // R5: boundary 2525 stays, 2524 exits
    apply("R5", 1, 2525, 0, 1, 0);
    apply("R5", 1, 2524, 0, 1, 0);
    // R10: fresh run required after exit
    for (int i = 0; i < RUN_N; i++) apply("R10", 1, 2600, 1, 0, 0);
    apply("R3", 1, 2600, 0, 0, 0);
    enter_deep("R10");
    // R6: 2400 stays, 2399 exits
    apply("R6", 1, 2400, 0, 0, 0);
    apply("R6", 1, 2399, 0, 0, 0);
    // R1: shutdown from deep mode, then counting restarts
    enter_deep("R4");
    apply("R1", 1, 2600, 1, 0, 1);
    for (int i = 0; i <= RUN_N; i++) apply("R1", 1, 2600, 1, 0, 0);
    // shutdown mid-run clears the count
    apply("R1", 0, 2500, 0, 0, 1);
    for (int i = 0; i < 2; i++) apply("R3", 1, 2600, 1, 0, 0);
    apply("R1", 1, 2600, 1, 0, 1);
    for (int i = 0; i < RUN_N; i++) apply("R3", 1, 2600, 1, 0, 0);
    // full sweep: sample codes x flags x strobe, restarting deep mode as needed
    for (int e = 2380; e <= 2620; e += 5)
      for (int k = 0; k < 8; k++) begin
        if (m_deep == 0 && (k == 0)) enter_deep("R4");
        apply("R5,R6,R9", k & 1, e, (k >> 1) & 1, (k >> 2) & 1, 0);
      end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule